// File: doc/BRIEF.md
# Manchester Line Transmitter with Pre-emphasis Taps

This block turns a stream of parallel bytes into a 10 Mbit/s Manchester-coded serial signal for a twisted-pair line driver. Bytes arrive over a valid/ready handshake. Each byte carries a start-of-frame flag and an end-of-frame flag. The system clock runs faster than the line rate. A one-cycle enable, `hb_tick`, pulses once per half-bit (20 MHz), and every change on the line happens on a clock edge where that enable is high.

The block drives four single-bit outputs. The first is the true coded signal and the second is its complement. The other two are copies of that pair, delayed by one half-bit, which an external resistor network mixes with the undelayed pair to apply pre-emphasis. After the last bit of a frame, the true output is held high and the complement low for two half-bits. All outputs then fall to the quiet idle state, where no differential voltage is driven.

The controller is a three-state machine:
- IDLE: the line is quiet, and the block waits for a byte marked as start of frame.
- SEND: a byte is being shifted out. At the end of each byte the machine takes either the RELOAD transition, which loads the next byte back to back, or the TAIL transition, which moves to HOLD.
- HOLD: counts the hold period, then takes the FINISH transition back to IDLE.

The START transition goes from IDLE to SEND. The DISCARD self-loop in IDLE drops a byte offered without the start flag.

Top module: `manchester_tx`

## Requirements
- R1: While reset is asserted, and after its release until the first byte is accepted, all four line outputs are low.
- R2: During SEND, a data bit of 1 puts `line_p` low in the first half-bit and high in the second; a 0 puts it high then low. `line_n` is always the inverse of `line_p`.
- R3: Bits leave least significant first. Each half-bit lasts exactly one `hb_tick` interval, and line outputs change only on edges where `hb_tick` is high.
- R4: `line_pd` and `line_nd` equal the values that `line_p` and `line_n` had one half-bit earlier. They are updated on each edge where `hb_tick` is high.
- R5: After the last half-bit of a frame, `line_p` is high and `line_n` low for exactly two half-bits. Both then go low.
- R6: In IDLE, `line_p` and `line_n` are both low.
- R7: `in_ready` is high only while `hb_tick` is high, and then only in IDLE, or in SEND during the final half-bit of a byte that was not flagged end of frame. A byte transfers when `in_valid` and `in_ready` are both high at a clock edge.
- R8: A byte accepted in IDLE without `in_sof` set is dropped: the line stays quiet.
- R9: If no byte is offered at the end of a byte that was not flagged end of frame, the frame ends exactly as at an end-of-frame byte (HOLD, then IDLE).
- R10: A byte accepted at the end of the previous byte starts on the very next half-bit, with no gap on the line; `in_sof` is ignored during SEND.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_tick | input | 1 | Half-bit enable, one clock wide, 20 MHz rate |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` and flags are valid |
| in_sof | input | 1 | Byte opens a frame |
| in_eof | input | 1 | Byte closes a frame |
| in_ready | output | 1 | Block takes the byte at this edge |
| line_p | output | 1 | True Manchester output |
| line_n | output | 1 | Complement Manchester output |
| line_pd | output | 1 | `line_p` delayed one half-bit |
| line_nd | output | 1 | `line_n` delayed one half-bit |

## Verification
The hardest situations to reach are the two ways a frame can end without an end-of-frame byte: a byte missing at the single-cycle ready window, and a byte offered in IDLE without a start flag. The stimulus schedules per-byte gaps so that one frame starves after its first byte and one stray byte waits until the line goes idle. Both the HOLD entered by starvation and the DISCARD loop are then compared cycle by cycle against the behavioural model. Back-to-back reloads within a three-byte frame, and a new frame that starts on the first tick after FINISH, cover the RELOAD and START timing.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_HOLD = 2'd2
    } mtx_state_e;
endpackage

// File: rtl/mtx_serial.sv
module mtx_serial #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hb_tick,
    input  logic              active,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    output logic              cur_bit,
    output logic              half,
    output logic              last_half
);
    localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] sreg;
    logic [IDX_W-1:0]  idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            idx  <= '0;
            half <= 1'b0;
        end else if (load) begin
            sreg <= load_data;
            idx  <= '0;
            half <= 1'b0;
        end else if (hb_tick && active) begin
            if (!half) begin
                half <= 1'b1;
            end else begin
                half <= 1'b0;
                idx  <= idx + 1'b1;
                sreg <= sreg >> 1;
            end
        end
    end

    assign cur_bit   = sreg[0];
    assign last_half = half && (idx == LAST_IDX);

    // R3: position advances only on a tick
    p_idx_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hb_tick && !load) |=> $stable(idx) && $stable(half));
endmodule

// File: rtl/mtx_ctrl.sv
module mtx_ctrl
    import mtx_pkg::*;
#(
    parameter int HOLD_HB = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hb_tick,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic       last_half,
    output logic       in_ready,
    output logic       load,
    output mtx_state_e state
);
    localparam int HC_W = (HOLD_HB > 1) ? $clog2(HOLD_HB) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HOLD_HB - 1);

    mtx_state_e      state_nx;
    logic [HC_W-1:0] hcnt, hcnt_nx;
    logic            eof_q, eof_nx;
    logic            accept;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            hcnt  <= '0;
            eof_q <= 1'b0;
        end else begin
            state <= state_nx;
            hcnt  <= hcnt_nx;
            eof_q <= eof_nx;
        end
    end

    // next-state and output process
    always_comb begin
        state_nx = state;
        hcnt_nx  = hcnt;
        eof_nx   = eof_q;
        in_ready = 1'b0;
        load     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                in_ready = hb_tick;
                if (in_valid && hb_tick && in_sof) begin   // START
                    load     = 1'b1;
                    eof_nx   = in_eof;
                    state_nx = ST_SEND;
                end                                        // else DISCARD
            end
            ST_SEND: begin
                in_ready = hb_tick && last_half && !eof_q;
                if (hb_tick && last_half) begin
                    if (in_valid && !eof_q) begin          // RELOAD
                        load   = 1'b1;
                        eof_nx = in_eof;
                    end else begin                         // TAIL
                        hcnt_nx  = '0;
                        state_nx = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (hb_tick) begin
                    if (hcnt == HC_LAST) begin             // FINISH
                        state_nx = ST_IDLE;
                    end else begin
                        hcnt_nx = hcnt + 1'b1;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign accept = in_valid && in_ready;

    p_ready_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> hb_tick);
    p_drop_no_sof_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && accept && !in_sof) |=> state == ST_IDLE);
    p_starve_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && hb_tick && last_half && !accept) |=> state == ST_HOLD);
    p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && accept) |=> state == ST_SEND);
endmodule

// File: rtl/mtx_delay.sv
module mtx_delay #(
    parameter int LANES = 2,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] dout
);
    logic [LANES-1:0] stage [DEPTH];

    genvar s;
    generate
        for (s = 0; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage[s] <= '0;
                end else if (adv) begin
                    if (s == 0) stage[s] <= din;
                    else        stage[s] <= stage[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/manchester_tx.sv
module manchester_tx
    import mtx_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int HOLD_HB  = 2,
    parameter int DELAY_HB = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hb_tick,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              in_ready,
    output logic              line_p,
    output logic              line_n,
    output logic              line_pd,
    output logic              line_nd
);
    mtx_state_e state;
    logic       load, cur_bit, half, last_half;
    logic [1:0] dly_out;

    mtx_ctrl #(.HOLD_HB(HOLD_HB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .hb_tick(hb_tick),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .last_half(last_half), .in_ready(in_ready), .load(load),
        .state(state)
    );

    mtx_serial #(.BYTE_W(BYTE_W)) u_serial (
        .clk(clk), .rst_n(rst_n), .hb_tick(hb_tick),
        .active(state == ST_SEND), .load(load), .load_data(in_data),
        .cur_bit(cur_bit), .half(half), .last_half(last_half)
    );

    // line encoding from registered state
    always_comb begin
        line_p = 1'b0;
        line_n = 1'b0;
        unique case (state)
            ST_SEND: begin
                line_p = ~(cur_bit ^ half);
                line_n = cur_bit ^ half;
            end
            ST_HOLD: begin
                line_p = 1'b1;
                line_n = 1'b0;
            end
            default: begin
                line_p = 1'b0;
                line_n = 1'b0;
            end
        endcase
    end

    mtx_delay #(.LANES(2), .DEPTH(DELAY_HB)) u_delay (
        .clk(clk), .rst_n(rst_n), .adv(hb_tick),
        .din({line_n, line_p}), .dout(dly_out)
    );
    assign line_pd = dly_out[0];
    assign line_nd = dly_out[1];

    p_no_both_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_p && line_n));
    p_line_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hb_tick |=> $stable(line_p) && $stable(line_n));
    p_hold_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && hb_tick && last_half && !(in_valid && in_ready))
        |=> line_p && !line_n);
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !line_p && !line_n);

    generate
        if (DELAY_HB == 1) begin : g_dly_chk
            p_delay_tap_r4: assert property (@(posedge clk) disable iff (!rst_n)
                hb_tick |=> (line_pd == $past(line_p)) && (line_nd == $past(line_n)));
        end
    endgenerate
endmodule

// File: tb/tb_manchester_tx.sv
module tb_manchester_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hb_tick = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic       in_ready, line_p, line_n, line_pd, line_nd;

    always #5 clk = ~clk;

    manchester_tx dut (
        .clk(clk), .rst_n(rst_n), .hb_tick(hb_tick), .in_data(in_data),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_ready(in_ready), .line_p(line_p), .line_n(line_n),
        .line_pd(line_pd), .line_nd(line_nd)
    );

    int checks = 0, errors = 0;

    // model state: 0 idle, 1 send, 2 hold
    int ms = 0, mbit = 0, mhalf = 0, meof = 0, mhc = 0, mbyte = 0;
    int ep = 0, en = 0, epd = 0, end_ = 0;
    int starved = 0, dropped = 0, reloads = 0, n_starve = 0;

    logic [7:0] it_d [8];
    int it_s [8], it_e [8], it_g [8];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_ready(input int hb);
        return (hb != 0) && (ms == 0 || (ms == 1 && mbit == 7 && mhalf == 1 && meof == 0));
    endfunction

    task automatic model_outputs();
        if (ms == 1) begin
            int b;
            b = (mbyte >> mbit) & 1;
            ep = (mhalf != 0) ? b : 1 - b;
            en = 1 - ep;
        end else if (ms == 2) begin
            ep = 1; en = 0;
        end else begin
            ep = 0; en = 0;
        end
    endtask

    initial begin
        int idx, gapc, hbc, cyc, tail;
        int acc, rdy;
        string t;
        it_d[0] = 8'hA5; it_s[0] = 1; it_e[0] = 1; it_g[0] = 10;
        it_d[1] = 8'h5A; it_s[1] = 0; it_e[1] = 1; it_g[1] = 20;
        it_d[2] = 8'h00; it_s[2] = 1; it_e[2] = 0; it_g[2] = 0;
        it_d[3] = 8'hFF; it_s[3] = 1; it_e[3] = 0; it_g[3] = 0;
        it_d[4] = 8'h3C; it_s[4] = 0; it_e[4] = 1; it_g[4] = 0;
        it_d[5] = 8'h81; it_s[5] = 1; it_e[5] = 0; it_g[5] = 30;
        it_d[6] = 8'hC3; it_s[6] = 1; it_e[6] = 1; it_g[6] = 300;
        it_d[7] = 8'h7E; it_s[7] = 1; it_e[7] = 1; it_g[7] = 0;

        repeat (3) @(negedge clk);
        chk("R1 line_p in reset", int'(line_p), 0);
        chk("R1 line_n in reset", int'(line_n), 0);
        chk("R1 line_pd in reset", int'(line_pd), 0);
        chk("R1 line_nd in reset", int'(line_nd), 0);
        rst_n = 1'b1;

        idx = 0; gapc = it_g[0]; hbc = 0; cyc = 0; tail = 0;
        while (tail < 60 && cyc < 6000) begin
            @(negedge clk);
            cyc++;
            // compare outputs against model
            if (ms == 1)      t = "R2 R3 R10";
            else if (ms == 2) t = (starved != 0) ? "R5 R9" : "R5";
            else              t = (dropped != 0) ? "R6 R8" : (cyc < 12 ? "R1 R6" : "R6");
            chk({t, " line_p"}, int'(line_p), ep);
            chk({t, " line_n"}, int'(line_n), en);
            chk("R4 line_pd", int'(line_pd), epd);
            chk("R4 line_nd", int'(line_nd), end_);
            // drive next inputs
            hbc = (hbc + 1) % 5;
            hb_tick = (hbc == 4);
            if (idx < 8 && gapc == 0) begin
                in_valid = 1'b1; in_data = it_d[idx];
                in_sof = it_s[idx][0]; in_eof = it_e[idx][0];
            end else begin
                in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0;
                if (gapc > 0) gapc--;
            end
            #1;
            rdy = model_ready(int'(hb_tick));
            chk("R7 in_ready", int'(in_ready), rdy);
            acc = int'(in_valid) & rdy;
            // step model across the coming edge
            if (hb_tick) begin epd = ep; end_ = en; end
            if (ms == 0) begin
                if (acc != 0 && in_sof) begin
                    ms = 1; mbyte = in_data; mbit = 0; mhalf = 0; meof = in_eof;
                    dropped = 0; starved = 0;
                end else if (acc != 0) begin
                    dropped = 1;
                end
            end else if (ms == 1) begin
                if (hb_tick) begin
                    if (mbit == 7 && mhalf == 1) begin
                        if (acc != 0) begin
                            mbyte = in_data; mbit = 0; mhalf = 0; meof = in_eof;
                            reloads++;
                        end else begin
                            if (meof == 0) begin starved = 1; n_starve++; end
                            ms = 2; mhc = 0;
                        end
                    end else if (mhalf == 0) mhalf = 1;
                    else begin mhalf = 0; mbit++; end
                end
            end else begin
                if (hb_tick) begin
                    if (mhc == 1) ms = 0; else mhc++;
                end
            end
            model_outputs();
            if (acc != 0) begin
                idx++;
                if (idx < 8) gapc = it_g[idx];
            end
            if (idx >= 8 && ms == 0) tail++;
        end
        if (cyc >= 6000) begin
            checks++; errors++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 6000);
        end
        chk("R9 starved frames seen", n_starve, 1);
        chk("R10 reloads seen", reloads, 2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule